// File: doc/BRIEF.md
# Nonvolatile Configuration Memory Write Sequencer

This block manages host writes into a small nonvolatile byte array that holds card configuration data. The host signals a write by holding both its card-enable and write-enable strobes low (both active low). The write is committed when whichever strobe returns high first. At that moment the block keeps the address and data that were present during the last sampled strobe cycle. It then starts an internal programming cycle of fixed length and holds its ready output low for the whole cycle.

While the programming cycle runs, any new write strobe is dropped. Reads go on as normal and return the contents the array had before the cycle began. When the cycle ends, the captured byte is written into the array and the ready output goes high again. A power-up inhibit input blocks writes completely while it is high. The cell array is modelled as registers that reset to the erased value 8'hFF. The cycle length is a clock-count parameter: at the default, 2,000,000 cycles of a 200 MHz clock give 10 ms, and a bench can set a much smaller value.

Top module: `nvm_prog_seq`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (256 x 8 by default). With the read-mode parameter left at its default (combinational read), `rdata_o` shows the word at `addr_i` in the same cycle.
- R2: A write is launched on the first clock edge that sees the strobe pair no longer both low after at least one edge saw both low. Which strobe rose first does not matter. `ready_o` reads 0 (busy) starting from that edge.
- R3: `ready_o` stays 0 for exactly CYCLE_CLKS clock cycles. On the edge that raises it back to 1, the captured data is written to the captured address.
- R4: The address and data written are those sampled on the last edge at which both strobes were low. Changes to `addr_i` or `wdata_i` after that have no effect on the write.
- R5: While `inhibit_i` is 1, no write starts: `ready_o` stays 1 and the array is unchanged. A strobe that begins while `inhibit_i` is 1 is also dropped.
- R6: A strobe that begins while `ready_o` is 0 is dropped. It does not change the array and does not lengthen the busy period.
- R7: During a busy period, reading any address, including the one being programmed, returns the contents from before the write.
- R8: After reset, `ready_o` is 1 and every word reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inhibit_i | input | 1 | Power-up write inhibit, active high |
| cen_n_i | input | 1 | Card enable strobe, active low, synchronous to clk |
| wen_n_i | input | 1 | Write enable strobe, active low, synchronous to clk |
| addr_i | input | ADDR_W | Address for both writes and reads |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| ready_o | output | 1 | 1 = ready, 0 = programming in progress |

## Verification
The assertions assume that the strobes and the inhibit input are already synchronous to `clk`. They also assume that an idle strobe pair rests with both lines high. The bench drives every input on the falling edge, so each level is stable at the rising edge that samples it. Each strobe pulse lasts at least two clock edges, and the bench changes address and data right after release to show that they were captured. A sweep writes all 256 words, alternating which strobe rises first. Further sequences cover inhibit and strobes issued while busy.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
   // Read port variant selected by generate in the cell array
   typedef enum logic {
      RD_COMB = 1'b0,
      RD_REG  = 1'b1
   } rd_mode_e;

   // 10 ms at 200 MHz
   localparam int unsigned DEFAULT_CYCLE_CLKS = 2_000_000;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/nvm_strobe_det.sv
module nvm_strobe_det #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cen_n_i,
   input  logic              wen_n_i,
   input  logic              inhibit_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              launch_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   logic              active;
   logic              active_q;
   logic              armed_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign active = !cen_n_i && !wen_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         armed_q  <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         active_q <= active;
         if (active && !active_q) begin
            armed_q <= !busy_i && !inhibit_i;
         end else if (!active) begin
            armed_q <= 1'b0;
         end
         if (active) begin
            addr_q <= addr_i;
            data_q <= wdata_i;
         end
      end
   end

   // End of strobe: either line returned high first
   assign launch_o = active_q && !active && armed_q && !inhibit_i && !busy_i;
   assign addr_o   = addr_q;
   assign data_o   = data_q;

   // R6
   // a pulse that began while busy never fires, even if busy ends first
   armed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !active_q && busy_i) |=> !launch_o);
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer
   import nvm_prog_pkg::*;
#(
   parameter int unsigned CYCLE_CLKS = DEFAULT_CYCLE_CLKS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned CNT_W = cnt_width(CYCLE_CLKS);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(CYCLE_CLKS - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

   // R3
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
   import nvm_prog_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter logic [7:0]  ERASED  = 8'hFF,
   parameter rd_mode_e    RD_MODE = RD_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][DATA_W-1:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells[g] <= DATA_W'(ERASED);
         end else if (we_i && waddr_i == ADDR_W'(g)) begin
            cells[g] <= wdata_i;
         end
      end
   end

   if (RD_MODE == RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_o <= DATA_W'(ERASED);
         end else begin
            rdata_o <= cells[raddr_i];
         end
      end
   end else begin : g_rd_comb
      assign rdata_o = cells[raddr_i];
   end

   // R6
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(cells));
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
   import nvm_prog_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CYCLE_CLKS = DEFAULT_CYCLE_CLKS,
   parameter rd_mode_e    RD_MODE    = RD_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inhibit_i,
   input  logic              cen_n_i,
   input  logic              wen_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ready_o
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 8) begin : g_bad_data
      $error("DATA_W out of range");
   end
   if (CYCLE_CLKS < 2) begin : g_bad_cycle
      $error("CYCLE_CLKS must be at least 2");
   end

   logic              launch;
   logic              busy;
   logic              commit;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_data_q;

   nvm_strobe_det #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) strobe_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cen_n_i   (cen_n_i),
      .wen_n_i   (wen_n_i),
      .inhibit_i (inhibit_i),
      .busy_i    (busy),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .launch_o  (launch),
      .addr_o    (cap_addr),
      .data_o    (cap_data)
   );

   // Request held stable for the whole programming cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr_q <= '0;
         req_data_q <= '0;
      end else if (launch) begin
         req_addr_q <= cap_addr;
         req_data_q <= cap_data;
      end
   end

   nvm_busy_timer #(.CYCLE_CLKS(CYCLE_CLKS)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (launch),
      .busy_o  (busy),
      .done_o  (commit)
   );

   nvm_cell_array #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .ERASED  (8'hFF),
      .RD_MODE (RD_MODE)
   ) cells_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit),
      .waddr_i (req_addr_q),
      .wdata_i (req_data_q),
      .raddr_i (addr_i),
      .rdata_o (rdata_o)
   );

   assign ready_o = !busy;

   // R2
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !ready_o);

   // R3
   ready_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(commit));

   // R5
   inhibit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_i && ready_o) |=> ready_o);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && !$past(launch)) |-> ($stable(req_addr_q) && $stable(req_data_q)));
endmodule

// File: tb/nvm_prog_seq_tb_top.sv
module nvm_prog_seq_tb_top;
   localparam int unsigned CYC = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       inhibit = 1'b0;
   logic       cen_n = 1'b1;
   logic       wen_n = 1'b1;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ready;

   int checks = 0;
   int fails = 0;
   int run_len = 0;
   int last_run = 0;
   logic [7:0] model [256];

   always #2.5 clk = ~clk;

   nvm_prog_seq #(.CYCLE_CLKS(CYC)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit_i (inhibit),
      .cen_n_i   (cen_n),
      .wen_n_i   (wen_n),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .ready_o   (ready)
   );

   // Length of the most recent busy run, counted at falling edges
   always @(negedge clk) begin
      if (!ready) begin
         run_len <= run_len + 1;
      end else if (run_len != 0) begin
         last_run <= run_len;
         run_len  <= 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int salt);
      return 8'((a * 37 + 5 + salt * 91) % 256);
   endfunction

   // Full strobe pulse; ce_first chooses which line rises first.
   // Address/data are scrambled right after the first line rises.
   task automatic strobe(input logic [7:0] a, input logic [7:0] d, input logic ce_first);
      @(negedge clk);
      addr = a; wdata = d; cen_n = 1'b0; wen_n = 1'b0;
      repeat (2) @(negedge clk);
      if (ce_first) cen_n = 1'b1; else wen_n = 1'b1;
      addr = ~a; wdata = ~d;
      @(negedge clk);
      cen_n = 1'b1; wen_n = 1'b1;
   endtask

   task automatic wait_ready();
      while (!ready) @(negedge clk);
      @(negedge clk);
      #0.5;
   endtask

   task automatic read_chk(input string req, input int a, input int exp);
      addr = 8'(a);
      #0.5;
      check(req, int'(rdata), exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      check("R8 ready", int'(ready), 1);
      for (int a = 0; a < 256; a++) begin
         read_chk("R8 erased", a, 255);
         model[a] = 8'hFF;
      end

      // R1/R2/R3/R4: write every word, alternating first-rising strobe
      for (int a = 0; a < 256; a++) begin
         strobe(8'(a), pat(a, 0), a[0]);
         check("R2 busy after launch", int'(ready), 0);
         wait_ready();
         check("R3 busy length", last_run, CYC);
         model[a] = pat(a, 0);
      end
      for (int a = 0; a < 256; a++) begin
         read_chk("R1 R4 readback", a, int'(model[a]));
      end

      // R7: old contents readable during programming
      for (int a = 0; a < 256; a += 17) begin
         strobe(8'(a), pat(a, 1), 1'b0);
         read_chk("R7 old value while busy", a, int'(model[a]));
         @(negedge clk);
         read_chk("R7 old value mid cycle", a, int'(model[a]));
         wait_ready();
         model[a] = pat(a, 1);
         read_chk("R3 new value after cycle", a, int'(model[a]));
      end

      // R6: strobe issued during busy is dropped
      for (int k = 0; k < 8; k++) begin
         strobe(8'(k * 5), pat(k, 2), k[0]);
         strobe(8'(200 + k), pat(k, 3), !k[0]);
         wait_ready();
         check("R6 busy not extended", last_run, CYC);
         model[k * 5] = pat(k, 2);
         read_chk("R6 first write kept", k * 5, int'(model[k * 5]));
         read_chk("R6 dropped write", 200 + k, int'(model[200 + k]));
      end

      // R5: inhibit blocks writes
      inhibit = 1'b1;
      for (int k = 0; k < 6; k++) begin
         strobe(8'(100 + k), pat(k, 4), k[0]);
         check("R5 ready stays high", int'(ready), 1);
         repeat (CYC + 2) @(negedge clk);
         check("R5 still ready", int'(ready), 1);
         read_chk("R5 unchanged", 100 + k, int'(model[100 + k]));
      end
      inhibit = 1'b0;
      strobe(8'd100, 8'h3C, 1'b1);
      check("R5 write after inhibit released", int'(ready), 0);
      wait_ready();
      read_chk("R5 write after inhibit released", 100, 16'h3C);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule